// File: doc/BRIEF.md
# Dual-Trigger Non-Retriggerable One-Shot

This block is a clocked monostable. It emits one pulse of programmable length when it sees a qualified trigger. A counter of clock cycles sets the length, so no RC network is involved. There are two trigger inputs. `trig_fall` acts on a high-to-low transition, but only while `trig_rise` is high. `trig_rise` acts on a low-to-high transition, but only while `trig_fall` is low. This lets either the leading or the trailing edge of a strobe start the pulse. While a pulse runs, all trigger activity is ignored.

A functional clear input, `clr_n`, cuts a pulse short the moment it goes low and keeps the output idle while it stays low. Its release can itself start a pulse if the trigger inputs went through an arming pattern while it was low. The pulse length comes from the `width` input and is sampled in the cycle the block fires. All inputs are assumed synchronous to `clk`. A system that needs two channels instantiates the block twice, each instance with its own `clr_n`.

Top module: `oneshot_dual_trig`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after it, the block is idle: `pulse` = 0 and `pulse_n` = 1, with no pulse pending.
- R2: With `clr_n` high and `trig_rise` high, a change of `trig_fall` from 1 (previous clock) to 0 (current clock) starts a pulse. `pulse` goes to 1 after that clock edge.
- R3: With `clr_n` high and `trig_fall` low, a change of `trig_rise` from 0 to 1 between consecutive clocks starts a pulse.
- R4: If `trig_fall` is high or `trig_rise` is low, a trigger edge on the other input starts nothing. An input held at its active level never starts a pulse without a fresh edge.
- R5: While a pulse is running, edges on `trig_fall`, `trig_rise` and `clr_n` neither restart nor extend it.
- R6: `pulse` stays high for exactly N clock cycles, where N is the value on `width` in the firing cycle. A value of 0 gives one cycle.
- R7: `clr_n` low forces `pulse` to 0 in the same cycle, without waiting for a clock. It also abandons the pulse in progress, so `pulse` stays 0 after `clr_n` returns high.
- R8: A rise of `clr_n` starts a pulse only if two things hold. While `clr_n` was low, at least one clock must have sampled `trig_fall` = 1 or `trig_rise` = 0. In the cycle `clr_n` rises, `trig_fall` must be 0 and `trig_rise` must be 1.
- R9: A fall of `trig_fall` and a rise of `trig_rise` in the same cycle start exactly one pulse.
- R10: After a pulse ends, a qualifying edge sampled on the very next clock edge starts the next pulse. `pulse` is low for a single cycle in between.
- R11: `pulse_n` is always the complement of `pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset (power-up) |
| clr_n | input | 1 | Functional clear, active low; its rise can fire when armed |
| trig_fall | input | 1 | Trigger acting on its falling edge |
| trig_rise | input | 1 | Trigger acting on its rising edge |
| width | input | WIDTH_W (8) | Pulse length in clock cycles, sampled when firing |
| pulse | output | 1 | One-shot output, high during the pulse |
| pulse_n | output | 1 | Complement of `pulse` |

## Verification
Two collisions matter most. One is a trigger edge landing in the same cycle that `clr_n` drops or rises. The other is the end of a pulse meeting a fresh edge on the next clock. Directed sequences produce both cases, and the random phase also toggles `clr_n` while edges are arriving. A cycle-level reference model in the bench judges every cycle. It tracks previous input values, the arming flag and the remaining count, and predicts `pulse` just before each rising edge.

// File: rtl/oneshot_pkg.sv
// Package: shared types and helpers for the dual-trigger one-shot.
// Assumes nothing beyond IEEE 1800-2017 packed structs.
package oneshot_pkg;

    // Per-cycle edge observations on the three control inputs.
    typedef struct packed {
        logic fall_a;   // trig_fall went 1 -> 0
        logic rise_b;   // trig_rise went 0 -> 1
        logic rise_r;   // clr_n went 0 -> 1
    } os_edges_t;

    // Reload value for the down counter: length minus one, zero length as one.
    function automatic logic [31:0] reload_of(input logic [31:0] len);
        return (len == 32'd0) ? 32'd0 : len - 32'd1;
    endfunction

endpackage

// File: rtl/os_edge_detect.sv
// Module: os_edge_detect
// Registers the previous value of each control input and reports edges
// by comparing it with the present value. Assumes inputs are already
// synchronous to clk. During reset the history follows the inputs, so
// no edge is reported on the first cycle after reset.
module os_edge_detect
    import oneshot_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      trig_fall,
    input  logic      trig_rise,
    input  logic      clr_n,
    output os_edges_t edges
);

    logic fall_q;
    logic rise_q;
    logic clr_q;

    // Purpose: keep one cycle of input history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fall_q <= trig_fall;
            rise_q <= trig_rise;
            clr_q  <= clr_n;
        end else begin
            fall_q <= trig_fall;
            rise_q <= trig_rise;
            clr_q  <= clr_n;
        end
    end

    // Purpose: compare history with the present to form edge flags.
    always_comb begin
        edges.fall_a = fall_q & ~trig_fall;
        edges.rise_b = ~rise_q & trig_rise;
        edges.rise_r = ~clr_q & clr_n & rst_n;
    end

endmodule

// File: rtl/os_arm_tracker.sv
// Module: os_arm_tracker
// Remembers whether, during the current low phase of clr_n, any clock
// saw trig_fall high or trig_rise low. The flag is the precondition for
// firing on the release of clr_n and clears once clr_n is high.
module os_arm_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n,
    input  logic trig_fall,
    input  logic trig_rise,
    output logic armed
);

    logic armed_q;

    // Purpose: set on the arming pattern while cleared, drop when released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (clr_n) begin
            armed_q <= 1'b0;
        end else if (trig_fall || !trig_rise) begin
            armed_q <= 1'b1;
        end
    end

    assign armed = armed_q;

    // R8: the flag can only be up if the clear was low on the previous clock.
    a_r8_arm_only_from_clear: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> $past(!clr_n));

endmodule

// File: rtl/os_width_timer.sv
// Module: os_width_timer
// Holds the pulse state and a down counter. On start it captures the
// length (zero treated as one) and then stays active for that many
// cycles. A low clr_n abandons the pulse at the next edge; the caller
// masks the output combinationally for the current cycle.
module os_width_timer
    import oneshot_pkg::*;
#(
    parameter int WIDTH_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_n,
    input  logic               start,
    input  logic [WIDTH_W-1:0] len,
    output logic               active
);

    localparam logic [WIDTH_W-1:0] ZERO = '0;

    logic               active_q;
    logic [WIDTH_W-1:0] remain_q;
    logic [31:0]        reload_w;

    assign reload_w = reload_of(32'(len));

    // Purpose: run the pulse state and its down counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            remain_q <= ZERO;
        end else if (!clr_n) begin
            active_q <= 1'b0;
            remain_q <= ZERO;
        end else if (start && !active_q) begin
            active_q <= 1'b1;
            remain_q <= reload_w[WIDTH_W-1:0];
        end else if (active_q) begin
            if (remain_q == ZERO) begin
                active_q <= 1'b0;
            end else begin
                remain_q <= remain_q - 1'b1;
            end
        end
    end

    assign active = active_q;

    // R7: a low clear at an edge leaves the pulse abandoned afterwards.
    a_r7_clear_abandons: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> !active_q);

    // R5: a running pulse with count left keeps running and counts down by one.
    a_r5_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && clr_n && remain_q != ZERO) |=>
            (active_q && remain_q == $past(remain_q) - 1'b1));

    // R6: a pulse only begins from a start request.
    a_r6_begin_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_q) |-> $past(start));

endmodule

// File: rtl/oneshot_dual_trig.sv
// Module: oneshot_dual_trig (top)
// Clocked non-retriggerable monostable with a falling-edge trigger, a
// rising-edge trigger, and an active-low clear whose release may fire
// after an arming pattern. Assumes all inputs synchronous to clk. The
// clear masks the output combinationally so a pulse stops in the same
// cycle the clear goes low.
module oneshot_dual_trig
    import oneshot_pkg::*;
#(
    parameter int WIDTH_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_n,
    input  logic               trig_fall,
    input  logic               trig_rise,
    input  logic [WIDTH_W-1:0] width,
    output logic               pulse,
    output logic               pulse_n
);

    os_edges_t edges;
    logic      armed;
    logic      active;
    logic      fire_fall;
    logic      fire_rise;
    logic      fire_clr;
    logic      start;

    os_edge_detect u_edges (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_fall (trig_fall),
        .trig_rise (trig_rise),
        .clr_n     (clr_n),
        .edges     (edges)
    );

    os_arm_tracker u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_n     (clr_n),
        .trig_fall (trig_fall),
        .trig_rise (trig_rise),
        .armed     (armed)
    );

    // Purpose: qualify each edge by the level of the other trigger input.
    always_comb begin
        fire_fall = edges.fall_a & trig_rise;
        fire_rise = edges.rise_b & ~trig_fall;
        fire_clr  = edges.rise_r & armed & ~trig_fall & trig_rise;
        start     = clr_n & rst_n & ~active & (fire_fall | fire_rise | fire_clr);
    end

    os_width_timer #(
        .WIDTH_W (WIDTH_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_n  (clr_n),
        .start  (start),
        .len    (width),
        .active (active)
    );

    // Purpose: drive the complementary outputs, masked by the clear.
    always_comb begin
        pulse   = active & clr_n;
        pulse_n = ~pulse;
    end

    // R2: a qualified falling edge while idle turns the output on next cycle.
    a_r2_fall_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (edges.fall_a && trig_rise && clr_n && !active) |=> active);

    // R4: with the blocking levels present and no clear release, nothing starts.
    a_r4_blocked_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && trig_fall && !trig_rise && !edges.rise_r) |=> !active);

endmodule

// File: tb/oneshot_dual_trig_tb.sv
module oneshot_dual_trig_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr_n = 1'b1;
    logic         trig_fall = 1'b1;
    logic         trig_rise = 1'b1;
    logic [W-1:0] width = '0;
    logic         pulse;
    logic         pulse_n;

    int total = 0;
    int bad = 0;

    // reference model state
    logic m_pa, m_pb, m_pr, m_arm, m_act;
    int   m_rem;

    always #2.5 clk = ~clk;

    oneshot_dual_trig #(.WIDTH_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n),
        .trig_fall(trig_fall), .trig_rise(trig_rise),
        .width(width), .pulse(pulse), .pulse_n(pulse_n)
    );

    function automatic logic exp_pulse(input logic act, input logic r);
        return act & r;
    endfunction

    function automatic int eff_len(input logic [W-1:0] w);
        return (w == 0) ? 1 : int'(w);
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
        end
    endtask

    // One cycle: drive, check before the edge, advance the model at the edge.
    task automatic step(input logic a, input logic b, input logic r,
                        input logic [W-1:0] w, input string tag);
        logic fire;
        logic n_arm, n_act;
        int   n_rem;
        @(negedge clk);
        trig_fall = a; trig_rise = b; clr_n = r; width = w;
        #1;
        check(tag, pulse, exp_pulse(m_act, r));
        check("R11", pulse_n, ~pulse);
        fire = r & ~m_act & ((m_pa & ~a & b) | (~m_pb & b & ~a) |
                             (~m_pr & r & m_arm & ~a & b));
        n_arm = r ? 1'b0 : (m_arm | a | ~b);
        n_act = m_act; n_rem = m_rem;
        if (!r) begin n_act = 1'b0; n_rem = 0; end
        else if (fire) begin n_act = 1'b1; n_rem = eff_len(w) - 1; end
        else if (m_act) begin
            if (m_rem == 0) n_act = 1'b0; else n_rem = m_rem - 1;
        end
        @(posedge clk);
        m_pa = a; m_pb = b; m_pr = r; m_arm = n_arm; m_act = n_act; m_rem = n_rem;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; trig_fall = 1'b1; trig_rise = 1'b1; clr_n = 1'b1;
        repeat (3) @(posedge clk);
        m_pa = 1'b1; m_pb = 1'b1; m_pr = 1'b1; m_arm = 1'b0; m_act = 1'b0; m_rem = 0;
        #1;
        check("R1", pulse, 1'b0);
        check("R1", pulse_n, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(trig_fall, trig_rise, clr_n, width, tag);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int seed;
        logic a, b, r;
        seed = 32'h5eed_0221;
        void'($urandom(seed));
        do_reset();
        idle(2, "R1");
        // R2: falling edge on trig_fall with trig_rise high, width 3
        step(1, 1, 1, 3, "R2"); step(0, 1, 1, 3, "R2"); idle(5, "R6");
        // R3: rising edge on trig_rise with trig_fall low, width 4
        step(0, 0, 1, 4, "R3"); step(0, 1, 1, 4, "R3"); idle(6, "R6");
        // R4: blocked edges and held levels
        step(1, 0, 1, 2, "R4"); step(0, 0, 1, 2, "R4"); step(1, 0, 1, 2, "R4");
        step(1, 1, 1, 2, "R4"); idle(4, "R4");
        // R6: zero width gives one cycle
        step(1, 1, 1, 0, "R6"); step(0, 1, 1, 0, "R6"); idle(3, "R6");
        // R5: edges during a pulse ignored
        step(1, 1, 1, 6, "R5"); step(0, 1, 1, 6, "R5"); step(1, 1, 1, 1, "R5");
        step(0, 1, 1, 1, "R5"); step(0, 0, 1, 1, "R5"); step(0, 1, 1, 1, "R5");
        idle(5, "R5");
        // R7: clear cuts short, pulse stays gone after release
        step(1, 1, 1, 8, "R7"); step(0, 1, 1, 8, "R7"); step(0, 1, 1, 8, "R7");
        step(0, 1, 0, 8, "R7"); step(0, 1, 0, 8, "R7"); step(0, 1, 1, 8, "R7");
        idle(4, "R7");
        // R8: release without arming does not fire
        step(0, 1, 0, 2, "R8"); step(0, 1, 0, 2, "R8"); step(0, 1, 1, 2, "R8");
        idle(3, "R8");
        // R8: armed release fires
        step(0, 1, 0, 2, "R8"); step(1, 1, 0, 2, "R8"); step(0, 1, 0, 2, "R8");
        step(0, 1, 1, 2, "R8"); idle(3, "R8");
        // R8: armed but wrong levels at release
        step(0, 0, 0, 2, "R8"); step(0, 0, 1, 2, "R8"); idle(3, "R8");
        // R9: simultaneous edges give one pulse
        step(1, 0, 1, 2, "R9"); step(0, 1, 1, 2, "R9"); idle(4, "R9");
        // R10: back-to-back with width 1
        step(1, 1, 1, 1, "R10"); step(0, 1, 1, 1, "R10"); step(1, 1, 1, 1, "R10");
        step(0, 1, 1, 1, "R10"); step(0, 1, 1, 1, "R10"); idle(2, "R10");
        // random mix, clears landing on edges
        for (int i = 0; i < 3000; i++) begin
            a = ($urandom % 3 == 0) ? ~trig_fall : trig_fall;
            b = ($urandom % 3 == 0) ? ~trig_rise : trig_rise;
            r = ($urandom % 8 == 0) ? ~clr_n : (clr_n | ($urandom % 2 == 0));
            step(a, b, r, W'($urandom % 6), "R5");
        end
        // reset mid-pulse returns idle
        step(1, 1, 1, 9, "R1"); step(0, 1, 1, 9, "R1");
        do_reset();
        idle(2, "R1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule